// File: doc/BRIEF.md
# Software-Filled Address Translation Cache

This block is a small, fully associative translation cache that maps 32-bit virtual addresses to physical addresses. It does not walk page tables. Software stages a tag word and a data word through a register port, points a replacement index at a slot, and issues a load command. The staged words are then copied into that slot. Four page granularities are supported: 4 KB, 64 KB, 1 MB and 16 MB. Each entry can be marked as protected. Protected entries survive the bulk invalidate, but not the targeted one.

The lookup side is purely combinational. A virtual address presented on `va_i` yields hit/miss, the physical address and three memory attribute fields within the same cycle. The replacement index lives in a lock register together with a protected-region base. The index never points below that base, and it advances automatically after each load.

Top module: `sw_tlb`

## Requirements
- R1: After reset every entry is invalid, every lookup misses, and reads of the lock (0x10), tag (0x24) and data (0x28) registers return 0.
- R2: A write to offset 0x24 stages the tag word and a write to 0x28 stages the data word, each byte lane gated by its byte enable. Reading either offset returns the staged word.
- R3: Writing a 1 in bit 0 of offset 0x20 copies the staged words into the entry at the replacement index. From the tag word, bits 31:12 give the virtual tag, bit 3 the protected flag, bit 2 the valid flag and bits 1:0 the size code (0 = 1 MB, 1 = 64 KB, 2 = 4 KB, 3 = 16 MB). From the data word, bits 31:12 give the physical page, bit 9 the endianness, bits 8:7 the element size and bit 6 the mixed-size flag.
- R4: A lookup hits when a valid entry's tag equals the virtual address on bits 31:12 (4 KB), 31:16 (64 KB), 31:20 (1 MB) or 31:24 (16 MB). Otherwise `miss_o` is 1, `hit_o` is 0, and `pa_o` and the attribute outputs are 0.
- R5: On a hit, `pa_o` takes the compared bits from the entry's physical page and all lower bits from the virtual address.
- R6: On a hit, `endian_o`, `elem_size_o` and `mixed_o` show the entry's data-word bits 9, 8:7 and 6.
- R7: The lock register at 0x10 holds the protected base in bits 20:16 and the replacement index in bits 4:0. Writing an index below the written base stores the base as the index.
- R8: After each load the replacement index increments. From 31 it wraps to the protected base.
- R9: Writing a 1 in bit 0 of offset 0x30 invalidates every entry whose size code equals the staged tag word's size code and whose tag matches the staged tag on that size's compared bits. This applies even to protected entries. Other entries are unchanged.
- R10: A write to 0x60 with byte enable 0 set and data bit 0 set invalidates every unprotected entry and leaves protected entries valid. Without both conditions, the write has no effect.
- R11: When several valid entries match, the lowest-numbered one supplies the outputs.
- R12: An entry loaded with its valid flag clear never produces a hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_be_i | input | 4 | Byte enables for the write |
| reg_rdata_o | output | 32 | Combinational read data at reg_addr_i |
| va_i | input | 32 | Virtual address to translate |
| hit_o | output | 1 | A valid entry matches va_i |
| miss_o | output | 1 | No valid entry matches va_i |
| pa_o | output | 32 | Translated physical address |
| endian_o | output | 1 | Endianness attribute of the hit entry |
| elem_size_o | output | 2 | Element size attribute of the hit entry |
| mixed_o | output | 1 | Mixed-size attribute of the hit entry |

## Verification
A corrupted entry field shows up on the very next lookup that addresses that page. A wrong tag or size appears as a wrong hit or miss. A wrong page or attribute appears on `pa_o` and the attribute pins, both in the same cycle as `va_i` is applied. A replacement index that drifts or skips the wrap becomes visible immediately in the lock register readback. It also shows later, as an entry landing in the wrong slot, which a subsequent targeted flush or priority lookup exposes. Flush errors remain latent until a lookup hits a page that should be gone, or misses a protected page that should have survived. For that reason, each flush is followed by lookups over the whole tag pool.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int unsigned TAG_W  = 20;
  localparam int unsigned REG_AW = 8;

  typedef enum logic [1:0] {
    PG_SECT  = 2'd0,
    PG_LARGE = 2'd1,
    PG_SMALL = 2'd2,
    PG_SUPER = 2'd3
  } pg_size_e;

  typedef struct packed {
    logic             valid;
    logic             keep;
    pg_size_e         size;
    logic [TAG_W-1:0] vtag;
    logic [TAG_W-1:0] ppn;
    logic             endian;
    logic [1:0]       esize;
    logic             mixed;
  } tlb_entry_t;

  localparam logic [REG_AW-1:0] OFS_LOCK   = 8'h10;
  localparam logic [REG_AW-1:0] OFS_LOAD   = 8'h20;
  localparam logic [REG_AW-1:0] OFS_CAM    = 8'h24;
  localparam logic [REG_AW-1:0] OFS_RAM    = 8'h28;
  localparam logic [REG_AW-1:0] OFS_FLUSH  = 8'h30;
  localparam logic [REG_AW-1:0] OFS_GFLUSH = 8'h60;

  localparam int unsigned LOCK_BASE_LSB = 16;

  // Tag bits compared for a page size (tag bit 0 = VA bit 12)
  function automatic logic [TAG_W-1:0] size_mask(pg_size_e s);
    case (s)
      PG_SMALL: return 20'hFFFFF;
      PG_LARGE: return 20'hFFFF0;
      PG_SECT:  return 20'hFFF00;
      default:  return 20'hFF000;
    endcase
  endfunction
endpackage

// File: rtl/tlb_regs.sv
module tlb_regs
  import tlb_pkg::*;
#(
  parameter int unsigned IDX_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  input  logic [3:0]        be_i,
  input  logic [IDX_W-1:0]  base_i,
  input  logic [IDX_W-1:0]  victim_i,
  output logic [31:0]       cam_o,
  output logic [31:0]       ram_o,
  output logic [31:0]       rdata_o,
  output logic              load_o,
  output logic              flush_o,
  output logic              gflush_o,
  output logic              lock_we_o,
  output logic [IDX_W-1:0]  base_wr_o,
  output logic [IDX_W-1:0]  victim_wr_o
);
  logic cam_sel, ram_sel;

  assign cam_sel = we_i && (addr_i == OFS_CAM);
  assign ram_sel = we_i && (addr_i == OFS_RAM);

  for (genvar b = 0; b < 4; b++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cam_o[8*b +: 8] <= '0;
        ram_o[8*b +: 8] <= '0;
      end else begin
        if (cam_sel && be_i[b]) cam_o[8*b +: 8] <= wdata_i[8*b +: 8];
        if (ram_sel && be_i[b]) ram_o[8*b +: 8] <= wdata_i[8*b +: 8];
      end
    end
  end

  assign load_o      = we_i && (addr_i == OFS_LOAD)   && be_i[0] && wdata_i[0];
  assign flush_o     = we_i && (addr_i == OFS_FLUSH)  && be_i[0] && wdata_i[0];
  assign gflush_o    = we_i && (addr_i == OFS_GFLUSH) && be_i[0] && wdata_i[0];
  assign lock_we_o   = we_i && (addr_i == OFS_LOCK);
  assign base_wr_o   = wdata_i[LOCK_BASE_LSB +: IDX_W];
  assign victim_wr_o = wdata_i[0 +: IDX_W];

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      OFS_LOCK: begin
        rdata_o[LOCK_BASE_LSB +: IDX_W] = base_i;
        rdata_o[0 +: IDX_W]             = victim_i;
      end
      OFS_CAM: rdata_o = cam_o;
      OFS_RAM: rdata_o = ram_o;
      default: rdata_o = '0;
    endcase
  end

  AST_CAM_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cam_sel |=> $stable(cam_o)); // R2
  AST_RAM_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ram_sel |=> $stable(ram_o)); // R2
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int unsigned ENTRIES = 32,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lock_we_i,
  input  logic [IDX_W-1:0] base_wr_i,
  input  logic [IDX_W-1:0] victim_wr_i,
  input  logic             load_i,
  output logic [IDX_W-1:0] base_o,
  output logic [IDX_W-1:0] victim_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_o   <= '0;
      victim_o <= '0;
    end else if (lock_we_i) begin
      base_o   <= base_wr_i;
      victim_o <= (victim_wr_i < base_wr_i) ? base_wr_i : victim_wr_i;
    end else if (load_i) begin
      victim_o <= (victim_o == LAST) ? base_o : victim_o + 1'b1;
    end
  end

  AST_VICTIM_ABOVE_BASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    victim_o >= base_o); // R7
  AST_VICTIM_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !lock_we_i && victim_o != LAST) |=> victim_o == $past(victim_o) + 1'b1); // R8
  AST_VICTIM_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !lock_we_i && victim_o == LAST) |=> victim_o == $past(base_o)); // R8
endmodule

// File: rtl/tlb_array.sv
module tlb_array
  import tlb_pkg::*;
#(
  parameter int unsigned ENTRIES = 32,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [IDX_W-1:0] load_idx_i,
  input  logic [31:0]      cam_i,
  input  logic [31:0]      ram_i,
  input  logic             flush_i,
  input  logic             gflush_i,
  input  logic [31:0]      va_i,
  output logic             hit_o,
  output logic [31:0]      pa_o,
  output logic             endian_o,
  output logic [1:0]       esize_o,
  output logic             mixed_o
);
  tlb_entry_t       ent_q [ENTRIES];
  tlb_entry_t       new_ent, sel_ent;
  logic [ENTRIES-1:0] hit_vec, valid_vec, keep_vec;
  pg_size_e         cam_size;
  logic [TAG_W-1:0] cam_mask, sel_mask;
  logic [IDX_W-1:0] sel_idx;
  logic             unused_bits;

  assign unused_bits = ^{cam_i[11:4], ram_i[11:10], ram_i[5:0]};
  assign cam_size    = pg_size_e'(cam_i[1:0]);
  assign cam_mask    = size_mask(cam_size);

  always_comb begin
    new_ent        = '0;
    new_ent.valid  = cam_i[2];
    new_ent.keep   = cam_i[3];
    new_ent.size   = cam_size;
    new_ent.vtag   = cam_i[31:12];
    new_ent.ppn    = ram_i[31:12];
    new_ent.endian = ram_i[9];
    new_ent.esize  = ram_i[8:7];
    new_ent.mixed  = ram_i[6];
  end

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    logic fl_match;
    assign fl_match = (ent_q[i].size == cam_size) &&
                      (((ent_q[i].vtag ^ cam_i[31:12]) & cam_mask) == '0);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ent_q[i] <= '0;
      else if (load_i && load_idx_i == IDX_W'(i)) ent_q[i] <= new_ent;
      else if (flush_i && fl_match) ent_q[i].valid <= 1'b0;
      else if (gflush_i && !ent_q[i].keep) ent_q[i].valid <= 1'b0;
    end

    assign valid_vec[i] = ent_q[i].valid;
    assign keep_vec[i]  = ent_q[i].keep;
    assign hit_vec[i]   = ent_q[i].valid &&
                          (((ent_q[i].vtag ^ va_i[31:12]) & size_mask(ent_q[i].size)) == '0);
  end

  // Lowest index wins
  always_comb begin
    sel_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (hit_vec[i]) sel_idx = IDX_W'(i);
  end

  assign sel_ent  = ent_q[sel_idx];
  assign sel_mask = size_mask(sel_ent.size);
  assign hit_o    = |hit_vec;

  always_comb begin
    pa_o     = '0;
    endian_o = 1'b0;
    esize_o  = '0;
    mixed_o  = 1'b0;
    if (hit_o) begin
      pa_o     = {(sel_ent.ppn & sel_mask) | (va_i[31:12] & ~sel_mask), va_i[11:0]};
      endian_o = sel_ent.endian;
      esize_o  = sel_ent.esize;
      mixed_o  = sel_ent.mixed;
    end
  end

  AST_LOAD_SETS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> valid_vec[$past(load_idx_i)] == $past(cam_i[2])); // R3
  AST_GFLUSH_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gflush_i && !load_i) |=> (valid_vec & ~keep_vec) == '0); // R10
  AST_GFLUSH_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gflush_i && !load_i) |=> (valid_vec & keep_vec) == $past(valid_vec & keep_vec)); // R10
  AST_FLUSH_NO_GROW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_i && !load_i) |=> $countones(valid_vec) <= $past($countones(valid_vec))); // R9
  AST_HIT_NEEDS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> valid_vec[sel_idx]); // R12
endmodule

// File: rtl/sw_tlb.sv
module sw_tlb
  import tlb_pkg::*;
#(
  parameter int unsigned ENTRIES = 32,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  input  logic [3:0]        reg_be_i,
  output logic [31:0]       reg_rdata_o,
  input  logic [31:0]       va_i,
  output logic              hit_o,
  output logic              miss_o,
  output logic [31:0]       pa_o,
  output logic              endian_o,
  output logic [1:0]        elem_size_o,
  output logic              mixed_o
);
  logic [31:0]      cam_w, ram_w;
  logic             load_w, flush_w, gflush_w, lock_we_w;
  logic [IDX_W-1:0] base_wr_w, victim_wr_w, base_w, victim_w;

  tlb_regs #(.IDX_W(IDX_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (reg_we_i),
    .addr_i      (reg_addr_i),
    .wdata_i     (reg_wdata_i),
    .be_i        (reg_be_i),
    .base_i      (base_w),
    .victim_i    (victim_w),
    .cam_o       (cam_w),
    .ram_o       (ram_w),
    .rdata_o     (reg_rdata_o),
    .load_o      (load_w),
    .flush_o     (flush_w),
    .gflush_o    (gflush_w),
    .lock_we_o   (lock_we_w),
    .base_wr_o   (base_wr_w),
    .victim_wr_o (victim_wr_w)
  );

  tlb_victim #(.ENTRIES(ENTRIES)) u_victim (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .lock_we_i   (lock_we_w),
    .base_wr_i   (base_wr_w),
    .victim_wr_i (victim_wr_w),
    .load_i      (load_w),
    .base_o      (base_w),
    .victim_o    (victim_w)
  );

  tlb_array #(.ENTRIES(ENTRIES)) u_array (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load_w),
    .load_idx_i (victim_w),
    .cam_i      (cam_w),
    .ram_i      (ram_w),
    .flush_i    (flush_w),
    .gflush_i   (gflush_w),
    .va_i       (va_i),
    .hit_o      (hit_o),
    .pa_o       (pa_o),
    .endian_o   (endian_o),
    .esize_o    (elem_size_o),
    .mixed_o    (mixed_o)
  );

  assign miss_o = ~hit_o;

  AST_MISS_ZERO_PA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_o |-> (pa_o == '0 && elem_size_o == '0 && !endian_o && !mixed_o)); // R4
  AST_PA_OFFSET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> pa_o[11:0] == va_i[11:0]); // R5
endmodule

// File: tb/sw_tlb_tb_top.sv
module sw_tlb_tb_top;
  localparam int N = 32;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wd = '0;
  logic [3:0]  bev = '0;
  logic [31:0] rdata;
  logic [31:0] va = '0;
  logic        hit, miss, endian, mixed;
  logic [31:0] pa;
  logic [1:0]  esize;

  always #4 clk = ~clk;

  sw_tlb #(.ENTRIES(N)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wd), .reg_be_i(bev), .reg_rdata_o(rdata), .va_i(va),
    .hit_o(hit), .miss_o(miss), .pa_o(pa), .endian_o(endian),
    .elem_size_o(esize), .mixed_o(mixed)
  );

  int errs = 0, checks = 0;
  bit done = 1'b0;

  bit        mv [N];
  bit        mk [N];
  bit [1:0]  msz [N];
  bit [19:0] mtag [N];
  bit [19:0] mppn [N];
  bit [3:0]  mat [N];
  int        mbase = 0, mvict = 0;
  bit [31:0] mcam = 0, mram = 0;

  function automatic bit [19:0] pmask(bit [1:0] s);
    case (s)
      2'd2:    return 20'hFFFFF;
      2'd1:    return 20'hFFFF0;
      2'd0:    return 20'hFFF00;
      default: return 20'hFF000;
    endcase
  endfunction

  function automatic bit [19:0] rtag();
    bit [19:0] t = 20'h0;
    t[19] = 1'($urandom); t[11] = 1'($urandom);
    t[7]  = 1'($urandom); t[1:0] = 2'($urandom);
    return t;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(bit [7:0] a, bit [31:0] d, bit [3:0] be = 4'hF);
    @(negedge clk);
    we = 1'b1; addr = a; wd = d; bev = be;
    @(negedge clk);
    we = 1'b0; addr = '0; wd = '0; bev = '0;
  endtask

  task automatic rd_chk(string req, bit [7:0] a, bit [31:0] exp);
    @(negedge clk);
    addr = a;
    #1 chk(req, rdata, exp);
  endtask

  task automatic stage(bit [31:0] c, bit [31:0] r);
    wr(8'h24, c); mcam = c;
    wr(8'h28, r); mram = r;
  endtask

  task automatic do_load();
    wr(8'h20, 32'h1);
    mv[mvict]   = mcam[2];
    mk[mvict]   = mcam[3];
    msz[mvict]  = mcam[1:0];
    mtag[mvict] = mcam[31:12];
    mppn[mvict] = mram[31:12];
    mat[mvict]  = {mram[9], mram[8:7], mram[6]};
    mvict = (mvict == N - 1) ? mbase : mvict + 1;
  endtask

  task automatic set_lock(int b, int v);
    wr(8'h10, (32'(b) << 16) | 32'(v));
    mbase = b;
    mvict = (v < b) ? b : v;
  endtask

  task automatic flush_one();
    wr(8'h30, 32'h1);
    for (int i = 0; i < N; i++)
      if (msz[i] == mcam[1:0] && ((mtag[i] ^ mcam[31:12]) & pmask(mcam[1:0])) == 0)
        mv[i] = 1'b0;
  endtask

  task automatic flush_all(bit [31:0] d, bit [3:0] be);
    wr(8'h60, d, be);
    if (be[0] && d[0])
      for (int i = 0; i < N; i++) if (!mk[i]) mv[i] = 1'b0;
  endtask

  task automatic look(string req, bit [31:0] v);
    bit eh = 1'b0;
    bit [31:0] epa = '0;
    bit [3:0] eat = '0;
    for (int i = 0; i < N; i++) begin
      if (!eh && mv[i] && ((mtag[i] ^ v[31:12]) & pmask(msz[i])) == 0) begin
        eh  = 1'b1;
        epa = {(mppn[i] & pmask(msz[i])) | (v[31:12] & ~pmask(msz[i])), v[11:0]};
        eat = mat[i];
      end
    end
    @(negedge clk);
    va = v;
    #1;
    chk(req, {hit, miss}, {eh, !eh});
    chk("R5 pa", pa, epa);
    chk("R6 attr", {endian, esize, mixed}, eat);
  endtask

  task automatic look_pool(string req);
    for (int k = 0; k < 12; k++) look(req, {rtag(), 12'($urandom)});
  endtask

  function automatic bit [31:0] mkram(bit [19:0] p, bit [3:0] at);
    return {p, 2'b00, at[3], at[2:1], at[0], 6'h0};
  endfunction

  initial begin
    void'($urandom(32'd7141));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1 reset state
    rd_chk("R1 lock", 8'h10, 32'h0);
    rd_chk("R1 cam", 8'h24, 32'h0);
    rd_chk("R1 ram", 8'h28, 32'h0);
    look("R1 miss", 32'h8001_2345);

    // R2 staging and byte lanes
    wr(8'h24, 32'hDEAD_BEEF, 4'b0101);
    rd_chk("R2 cam lanes", 8'h24, 32'h00AD_00EF);
    stage(32'h1234_500E, 32'hCAFE_1AC0);
    rd_chk("R2 cam", 8'h24, 32'h1234_500E);
    rd_chk("R2 ram", 8'h28, 32'hCAFE_1AC0);

    // R3/R4/R5/R6 one entry of each size
    stage({20'h80000, 12'h006}, mkram(20'hAAAAA, 4'b1011)); do_load(); // 4KB slot 0
    stage({20'h80810, 12'h005}, mkram(20'h55555, 4'b0100)); do_load(); // 64KB slot 1
    stage({20'h00800, 12'h004}, mkram(20'h12345, 4'b1110)); do_load(); // 1MB slot 2
    stage({20'h80800, 12'h007}, mkram(20'hFEDCB, 4'b0001)); do_load(); // 16MB slot 3
    rd_chk("R8 step", 8'h10, 32'd4);
    look("R4 small hit", 32'h8000_0ABC);
    look("R4 small miss", 32'h8000_1ABC);
    look("R4 large hit", 32'h8081_FFF0);
    look("R4 large miss", 32'h8082_0000);
    look("R4 section hit", 32'h0080_0001);
    look("R4 section hit2", 32'h008F_FFFF);
    look("R4 section miss", 32'h0090_0000);
    look("R4 super hit", 32'h80FF_FFFF);
    look("R4 super low", 32'h8000_1000);

    // R12 invalid entry never hits
    stage({20'h7777_7, 12'h00A}, mkram(20'h11111, 4'b0)); do_load();
    look("R12 invalid", 32'h7777_7000);

    // R11 duplicate match, lowest slot wins
    stage({20'h80000, 12'h006}, mkram(20'hBBBBB, 4'b0110)); do_load();
    look("R11 priority", 32'h8000_0004);

    // R7 clamp, R8 wrap
    set_lock(8, 2);
    rd_chk("R7 clamp", 8'h10, 32'h0008_0008);
    set_lock(8, 30);
    rd_chk("R7 write", 8'h10, 32'h0008_001E);
    stage({20'h40000, 12'h00E}, mkram(20'h22222, 4'b0)); do_load();
    stage({20'h41000, 12'h006}, mkram(20'h33333, 4'b0)); do_load();
    rd_chk("R8 wrap", 8'h10, 32'h0008_0008);
    look("R3 slot30 preserved", 32'h4000_0123);

    // R10 global flush ignored without bit 0 or lane 0
    flush_all(32'h0000_00FE, 4'hF);
    look_pool("R10 no data bit");
    look("R10 no data bit 1", 32'h4100_0000);
    flush_all(32'h0000_0001, 4'b1110);
    look("R10 no lane", 32'h4100_0000);
    flush_all(32'h0000_0001, 4'b0001);
    look("R10 keep survives", 32'h4000_0000);
    look("R10 plain gone", 32'h4100_0000);
    look_pool("R10 after");

    // R9 targeted flush removes a preserved entry, leaves other sizes
    stage({20'h40000, 12'h00D}, mkram(20'h44444, 4'b0)); do_load(); // 64KB same tag
    wr(8'h24, {20'h4000F, 12'h006}); mcam = {20'h4000F, 12'h006};
    flush_one(); // size 4KB differs in low tag bits: no match on 30
    look("R9 no match", 32'h4000_0000);
    wr(8'h24, {20'h40000, 12'h002}); mcam = {20'h40000, 12'h002};
    flush_one();
    look("R9 preserved flushed", 32'h4000_0000);
    look("R9 other size kept", 32'h4000_8000);

    // random mix
    for (int it = 0; it < 1500; it++) begin
      int op = int'($urandom % 10);
      if (op < 4) begin
        bit [31:0] c = {rtag(), 8'h0, 1'($urandom % 4 == 0), 1'($urandom % 8 != 0), 2'($urandom)};
        stage(c, mkram(20'($urandom), 4'($urandom)));
        do_load();
      end else if (op == 4) begin
        set_lock(int'($urandom % N), int'($urandom % N));
        rd_chk("R7 rand", 8'h10, (32'(mbase) << 16) | 32'(mvict));
      end else if (op == 5) begin
        bit [31:0] c = {rtag(), 10'h0, 2'($urandom)};
        wr(8'h24, c); mcam = c;
        flush_one();
        look_pool("R9 rand");
      end else if (op == 6) begin
        flush_all(32'($urandom % 4), 4'($urandom));
        look_pool("R10 rand");
      end else begin
        look("R4 rand", {rtag(), 12'($urandom)});
      end
      if (it % 50 == 0) rd_chk("R8 rand", 8'h10, (32'(mbase) << 16) | 32'(mvict));
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errs++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule